// File: doc/BRIEF.md
# Display Blink and Bank-Swap Controller

This block makes the blink timing of a segment display from the display clock and turns it into the two signals that govern what the display shows. The first is a blank request. The second is the output bank select that the RAM read path uses. A two-bit frequency code selects the blink period. The period is 768, 1536 or 3072 clock cycles, and code 0 switches blinking off. Every period splits into two equal halves. The first half is always the plain phase. The second half is the active phase.

In normal blinking, the active phase blanks the whole display. In alternate-bank blinking, the active phase shows the partner bank instead of the configured one. This mode works only in static and 1:2 multiplex drive, because only those modes have a partner bank. In 1:3 and 1:4 drive the block falls back to normal blinking. A cleared display-enable bit blanks the display whatever the blink phase is. Any change of the frequency code or of the blink mode restarts the period, so the display at once returns to the plain phase.

The block has no data stream. All of its pins are plain control and status levels, so no valid/ready handshake and no back-pressure apply.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: With `freq_code` = 1 and normal blinking, the period is 768 cycles. The display is unblanked for the first 384 cycles counted from the restart and blanked for the next 384.
- R2: With `freq_code` = 2 the period is 1536 cycles, and with `freq_code` = 3 it is 3072 cycles. Each period is split into equal plain and active halves.
- R3: With `freq_code` = 0 the blink phase never becomes active. `blank` equals the inverse of `disp_en`, and `bank_sel` equals `bank_cfg`.
- R4: In the active half of normal blinking, `blank` is 1 and `bank_sel` equals `bank_cfg`.
- R5: With `alt_mode` = 1 and `mux_mode` of 0 (static) or 1 (1:2), the active half drives `bank_sel` to the inverse of `bank_cfg` and keeps `blank` at 0. Bank value 0 selects the lower rows and 1 selects the upper rows.
- R6: With `mux_mode` of 2 (1:3) or 3 (1:4), `alt_mode` has no effect on the outputs. `bank_sel` equals `bank_cfg`, and the display blanks in the active half exactly as in normal blinking.
- R7: While `disp_en` is 0, `blank` is 1 in every cycle.
- R8: A change of `freq_code` or `alt_mode` sampled at a clock edge restarts the period at that edge. From the next cycle on, the display is in the plain phase, and the timing counts from zero.
- R9: While reset is held and after it is released, the block starts in the plain phase with the period counter at zero. `blank` is the inverse of `disp_en`, and `bank_sel` is `bank_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_code | input | 2 | Blink rate: 0 off, 1 = /768, 2 = /1536, 3 = /3072 |
| alt_mode | input | 1 | 0 normal blinking, 1 alternate-bank blinking |
| mux_mode | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| bank_cfg | input | 1 | Configured output bank |
| disp_en | input | 1 | Display enable; 0 forces blanking |
| blank | output | 1 | Blank the display this cycle |
| bank_sel | output | 1 | Effective output bank for RAM reads |

## Verification
Several relations are checked on every cycle. A disabled display is always blanked. The 1:3 and 1:4 modes never swap banks. Blanking and bank swapping never happen in the same cycle while the display is enabled. A held code 0 or a just-changed configuration gives the plain phase, and alternate-bank mode in static or 1:2 drive never blanks an enabled display. The exact half-period lengths of each frequency code, the edge at which a restart takes effect and the position of every toggle can only be shown by the bench. Its behavioural position model is compared with both outputs on every clock across all modes.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;

  localparam int FREQ_W = 2;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_1TO2   = 2'd1,
    MUX_1TO3   = 2'd2,
    MUX_1TO4   = 2'd3
  } mux_mode_e;

  // A partner bank exists only in the two lowest multiplex modes.
  function automatic logic has_partner_bank(input logic [1:0] mode);
    return (mode == MUX_STATIC) || (mode == MUX_1TO2);
  endfunction

endpackage

// File: rtl/lcd_blink_timebase.sv
module lcd_blink_timebase #(
  parameter int BASE_DIV = 768,
  parameter int FREQ_W   = 2,
  localparam int BASE_W  = $clog2(BASE_DIV),
  localparam int PRE_W   = (2 ** FREQ_W) - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic              alt_mode,
  output logic [FREQ_W-1:0] freq_q,
  output logic              alt_q,
  output logic [BASE_W-1:0] base_cnt,
  output logic [PRE_W-1:0]  pre_cnt
);

  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);

  logic restart;

  // Any configuration change, or blinking off, holds the counters at zero.
  assign restart = (freq_code != freq_q) || (alt_mode != alt_q) ||
                   (freq_code == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q   <= '0;
      alt_q    <= 1'b0;
      base_cnt <= '0;
      pre_cnt  <= '0;
    end else begin
      freq_q <= freq_code;
      alt_q  <= alt_mode;
      if (restart) begin
        base_cnt <= '0;
        pre_cnt  <= '0;
      end else if (base_cnt == BASE_LAST) begin
        base_cnt <= '0;
        pre_cnt  <= pre_cnt + 1'b1;
      end else begin
        base_cnt <= base_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_blink_phase.sv
module lcd_blink_phase #(
  parameter int BASE_DIV = 768,
  parameter int FREQ_W   = 2,
  localparam int BASE_W  = $clog2(BASE_DIV),
  localparam int PRE_W   = (2 ** FREQ_W) - 2,
  localparam int NTAP    = 2 ** FREQ_W
) (
  input  logic [FREQ_W-1:0] freq_q,
  input  logic [BASE_W-1:0] base_cnt,
  input  logic [PRE_W-1:0]  pre_cnt,
  output logic              active
);

  localparam logic [BASE_W-1:0] HALF = BASE_W'(BASE_DIV / 2);

  logic [NTAP-1:0] taps;

  // Code 0 never blinks; code 1 uses the upper half of the base count.
  assign taps[0] = 1'b0;
  assign taps[1] = (base_cnt >= HALF);

  // Higher codes double the period per step by taking a prescaler bit.
  for (genvar g = 0; g < PRE_W; g++) begin : g_tap
    assign taps[g+2] = pre_cnt[g];
  end

  assign active = taps[freq_q];

endmodule

// File: rtl/lcd_blink_out.sv
module lcd_blink_out
  import lcd_blink_pkg::*;
(
  input  logic       active,
  input  logic       alt_q,
  input  logic [1:0] mux_mode,
  input  logic       bank_cfg,
  input  logic       disp_en,
  output logic       blank,
  output logic       bank_sel
);

  logic swap_ok;

  assign swap_ok  = alt_q && has_partner_bank(mux_mode);
  assign blank    = !disp_en || (active && !swap_ok);
  assign bank_sel = bank_cfg ^ (active && swap_ok);

endmodule

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl #(
  parameter int BASE_DIV = 768,
  localparam int FREQ_W  = lcd_blink_pkg::FREQ_W,
  localparam int BASE_W  = $clog2(BASE_DIV),
  localparam int PRE_W   = (2 ** FREQ_W) - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic              alt_mode,
  input  logic [1:0]        mux_mode,
  input  logic              bank_cfg,
  input  logic              disp_en,
  output logic              blank,
  output logic              bank_sel
);

  logic [FREQ_W-1:0] freq_q;
  logic              alt_q;
  logic [BASE_W-1:0] base_cnt;
  logic [PRE_W-1:0]  pre_cnt;
  logic              active;

  lcd_blink_timebase #(.BASE_DIV(BASE_DIV), .FREQ_W(FREQ_W)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_code (freq_code),
    .alt_mode  (alt_mode),
    .freq_q    (freq_q),
    .alt_q     (alt_q),
    .base_cnt  (base_cnt),
    .pre_cnt   (pre_cnt)
  );

  lcd_blink_phase #(.BASE_DIV(BASE_DIV), .FREQ_W(FREQ_W)) u_phase (
    .freq_q   (freq_q),
    .base_cnt (base_cnt),
    .pre_cnt  (pre_cnt),
    .active   (active)
  );

  lcd_blink_out u_out (
    .active   (active),
    .alt_q    (alt_q),
    .mux_mode (mux_mode),
    .bank_cfg (bank_cfg),
    .disp_en  (disp_en),
    .blank    (blank),
    .bank_sel (bank_sel)
  );

endmodule

// File: rtl/lcd_blink_ctrl_chk.sv
module lcd_blink_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] freq_code,
  input logic       alt_mode,
  input logic [1:0] mux_mode,
  input logic       bank_cfg,
  input logic       disp_en,
  input logic       blank,
  input logic       bank_sel
);

  // R7
  disabled_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> blank);

  // R6
  no_swap_high_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_mode >= 2'd2) |-> (bank_sel == bank_cfg));

  // R4
  blank_xor_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !(blank && (bank_sel != bank_cfg)));

  // R3
  off_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((freq_code == 2'd0) && ($past(freq_code) == 2'd0) && disp_en)
      |-> (!blank && (bank_sel == bank_cfg)));

  // R5
  alt_never_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && $past(alt_mode) && (mux_mode <= 2'd1) && disp_en) |-> !blank);

  // R8
  restart_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((freq_code != $past(freq_code)) || (alt_mode != $past(alt_mode)))
      |=> ((!disp_en || !blank) && (bank_sel == bank_cfg)));

endmodule

bind lcd_blink_ctrl lcd_blink_ctrl_chk u_chk (.*);

// File: tb/lcd_blink_ctrl_bench.sv
module lcd_blink_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] freq_code = 2'd0;
  logic       alt_mode = 1'b0;
  logic [1:0] mux_mode = 2'd3;
  logic       bank_cfg = 1'b0;
  logic       disp_en = 1'b1;
  logic       blank;
  logic       bank_sel;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  // Reference state: cycles since restart and the registered configuration.
  int         pos = 0;
  logic [1:0] m_freq = 2'd0;
  logic       m_alt = 1'b0;

  always #4 clk = ~clk;

  lcd_blink_ctrl u_lcd_blink_ctrl (
    .clk (clk), .rst_n (rst_n), .freq_code (freq_code), .alt_mode (alt_mode),
    .mux_mode (mux_mode), .bank_cfg (bank_cfg), .disp_en (disp_en),
    .blank (blank), .bank_sel (bank_sel)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; m_freq = 2'd0; m_alt = 1'b0;
    end else begin
      if (freq_code != m_freq || alt_mode != m_alt || freq_code == 2'd0) pos = 0;
      else pos = pos + 1;
      m_freq = freq_code;
      m_alt  = alt_mode;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int  period;
      bit  act, swp, e_blank, e_bank;
      period = (m_freq == 2'd0) ? 1 : 768 * (1 << (m_freq - 1));
      act = (m_freq != 2'd0) && ((pos % period) >= period / 2);
      swp = m_alt && (mux_mode <= 2'd1);
      e_blank = !disp_en || (act && !swp);
      e_bank  = bank_cfg ^ (act && swp);
      n_checks++;
      if (blank !== e_blank || bank_sel !== e_bank) begin
        n_fail++;
        $display("FAIL %s pos=%0d blank=%b/%b bank_sel=%b/%b (actual/expected)",
                 cur_req, pos, blank, e_blank, bank_sel, e_bank);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    cur_req = "R9";
    step(5);
    rst_n = 1'b1;
    step(10);

    cur_req = "R3";
    step(700); bank_cfg = 1'b1; step(900); bank_cfg = 1'b0; disp_en = 1'b1;

    cur_req = "R1"; freq_code = 2'd1; step(3 * 768);
    cur_req = "R4"; bank_cfg = 1'b1; step(2 * 768); bank_cfg = 1'b0;

    cur_req = "R2"; freq_code = 2'd2; step(2 * 1536 + 5);
    freq_code = 2'd3; step(2 * 3072 + 5);

    cur_req = "R5"; alt_mode = 1'b1; mux_mode = 2'd0; freq_code = 2'd1;
    step(2 * 768);
    mux_mode = 2'd1; bank_cfg = 1'b1; freq_code = 2'd2; step(2 * 1536);

    cur_req = "R6"; mux_mode = 2'd2; bank_cfg = 1'b0; freq_code = 2'd1;
    step(2 * 768);
    mux_mode = 2'd3; bank_cfg = 1'b1; step(2 * 768);

    cur_req = "R7"; alt_mode = 1'b0; disp_en = 1'b0; step(1000);
    disp_en = 1'b1; step(300); disp_en = 1'b0; step(300); disp_en = 1'b1;

    cur_req = "R8"; freq_code = 2'd1; step(500);
    freq_code = 2'd2; step(600);
    alt_mode = 1'b1; mux_mode = 2'd0; step(1000);
    alt_mode = 1'b0; step(1);
    freq_code = 2'd3; step(2000);
    freq_code = 2'd1; step(400);

    cur_req = "R9"; rst_n = 1'b0; step(3); rst_n = 1'b1; step(800);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule